// File: doc/BRIEF.md
# Serially Programmed Power-Level Table

This block holds eight byte-wide power settings behind an SPI slave. A host reaches the whole table through one reserved header address. There is no per-entry address. A hidden pointer picks the entry. The pointer steps forward after every data byte moved in either direction, and it rolls over from the last entry back to the first. Raising chip select always returns the pointer to entry 0. Each transaction therefore starts at the bottom of the table.

A separate 3-bit select input, driven by the power-control logic, picks one entry. That entry appears on a parallel output. A sleep request erases every entry except entry 0. Entry 0 keeps the base power setting through sleep.

The SPI pins are sampled into the system clock domain. For this reason the serial clock must run well below the system clock. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pwr_table_spi`

## Requirements
- R1: After reset every entry reads 0x00, the pointer is at entry 0 and `spi_miso` is 0.
- R2: The first byte after chip select falls is a header, sent MSB first in SPI mode 0. Bit 7 is the direction (0 write, 1 read), bit 6 selects burst (1) or single byte (0), and bits 5:0 are the address. Only address 0x3E engages the table. A header carrying any other address leaves every entry unchanged.
- R3: In a write burst, successive data bytes go to entries 0, 1, 2 and onward.
- R4: The pointer wraps from entry 7 to entry 0 and keeps going. A ninth written byte replaces entry 0, and a ninth read byte returns entry 0.
- R5: In a read burst, `spi_miso` returns entries in ascending order starting at entry 0, MSB first. Each bit is valid before the rising serial clock edge that samples it.
- R6: In single-byte mode only the first data byte is acted on. Later bytes before chip select rises write nothing and read back as 0x00.
- R7: Chip select high resets the pointer to 0. Two separate single-byte writes therefore both land in entry 0.
- R8: `pa_level` always shows the entry chosen by `pa_sel`.
- R9: While `sleep_req` is high, entries 1 to 7 are cleared to 0x00 and entry 0 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| sleep_req | input | 1 | Sleep entry, clears entries 1 to 7 |
| pa_sel | input | 3 | Entry select for the power-control output |
| pa_level | output | 8 | Selected table entry |

## Verification
The bench targets the following corner cases:

- **Pointer rollover.** It makes a ninth write and a ninth and tenth read. A pointer that saturates at 7, or fails to wrap, would overwrite entry 7 or return it again.
- **Single-byte mode.** A trailing byte follows the first data byte. A design that ignores the burst bit would write that byte into entry 1, or shift real data back out during the read.
- **Pointer clear on chip select.** Two single writes must both land in entry 0. A pointer not cleared by chip select would put the second write in entry 1.
- **Foreign address.** A header with a different address must leave the table intact.
- **Sleep retention.** After a sleep pulse, entry 0 must keep its value while every other entry reads zero. This catches a clear that hits all entries, or one that misses some.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ACC_HDR  = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2,
    ACC_SKIP = 2'd3
  } acc_st_t;

  typedef struct packed {
    logic       rd;
    logic       burst;
    logic [5:0] addr;
  } hdr_t;
endpackage

// File: rtl/pt_spi_front.sv
module pt_spi_front #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              cs_idle,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck_fall,
  output logic              bit_zero
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sck_s, cs_s, mosi_s;
  logic                   sck_d;
  logic [BIT_W-1:0]       bit_q, bit_n;
  logic [DATA_W-1:0]      sh_q, sh_n;
  logic                   sck_now, mosi_now, sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[SYNC_STAGES-2:0], sck};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sck_d  <= sck_now;
    end
  end

  assign sck_now  = sck_s[SYNC_STAGES-1];
  assign mosi_now = mosi_s[SYNC_STAGES-1];
  assign cs_idle  = cs_s[SYNC_STAGES-1];
  assign sck_rise = sck_now & ~sck_d;
  assign sck_fall = ~sck_now & sck_d;
  assign bit_zero = (bit_q == '0);
  assign rx_byte  = {sh_q[DATA_W-2:0], mosi_now};
  assign byte_done = sck_rise & ~cs_idle & (bit_q == LAST_BIT);

  always_comb begin
    bit_n = bit_q;
    sh_n  = sh_q;
    if (cs_idle) begin
      bit_n = '0;
    end else if (sck_rise) begin
      sh_n  = rx_byte;
      bit_n = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      bit_q <= bit_n;
      sh_q  <= sh_n;
    end
  end

  // R7
  bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> bit_q == '0);
endmodule

// File: rtl/pt_index.sv
module pt_index #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_inc
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_n;

  assign idx_inc = (idx == TOP) ? '0 : idx + 1'b1;

  always_comb begin
    idx_n = idx;
    if (clr)      idx_n = '0;
    else if (adv) idx_n = idx_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_n;
  end

  // R7
  idx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> idx == '0);
  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && idx == TOP) |=> idx == '0);
  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && idx != TOP) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/pt_store.sv
module pt_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sleep,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] view [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic [DATA_W-1:0] q, n;
    logic              hit;

    assign hit = we && (waddr == IDX_W'(k));

    if (k == 0) begin : g_keep
      always_comb begin
        n = q;
        if (hit) n = wdata;
      end
      // R9
      keep_e0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !hit) |=> $stable(q));
    end else begin : g_lose
      always_comb begin
        n = q;
        if (sleep)    n = '0;
        else if (hit) n = wdata;
      end
      // R9
      sleep_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= n;
    end

    assign view[k] = q;
  end

  assign rdata_a = view[raddr_a];
  assign rdata_b = view[raddr_b];
endmodule

// File: rtl/pwr_table_spi.sv
module pwr_table_spi #(
  parameter int          DEPTH       = 8,
  parameter int          DATA_W      = 8,
  parameter logic [5:0]  TBL_ADDR    = 6'h3E,
  parameter int          SYNC_STAGES = 2,
  localparam int         IDX_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              sleep_req,
  input  logic [IDX_W-1:0]  pa_sel,
  output logic [DATA_W-1:0] pa_level
);
  import pt_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_sn;
  logic              cs_idle, byte_done, sck_fall, bit_zero;
  logic [DATA_W-1:0] rx_byte, rd_a, tx_q, tx_n;
  logic [IDX_W-1:0]  idx, idx_inc, rd_addr;
  logic              we, adv, burst_q, burst_n;
  acc_st_t           st_q, st_n;
  hdr_t              hdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  pt_spi_front #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_sn), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .cs_idle(cs_idle), .byte_done(byte_done), .rx_byte(rx_byte),
    .sck_fall(sck_fall), .bit_zero(bit_zero)
  );

  pt_index #(.DEPTH(DEPTH)) u_idx (
    .clk(clk), .rst_n(rst_sn), .clr(cs_idle), .adv(adv),
    .idx(idx), .idx_inc(idx_inc)
  );

  assign rd_addr = (st_q == ACC_RD) ? idx_inc : idx;

  pt_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_sn), .we(we), .waddr(idx), .wdata(rx_byte),
    .sleep(sleep_req), .raddr_a(rd_addr), .rdata_a(rd_a),
    .raddr_b(pa_sel), .rdata_b(pa_level)
  );

  assign hdr = hdr_t'(rx_byte[7:0]);

  always_comb begin
    st_n    = st_q;
    burst_n = burst_q;
    tx_n    = tx_q;
    we      = 1'b0;
    adv     = 1'b0;
    if (cs_idle) begin
      st_n = ACC_HDR;
      tx_n = '0;
    end else if (byte_done) begin
      unique case (st_q)
        ACC_HDR: begin
          if (hdr.addr == TBL_ADDR) begin
            burst_n = hdr.burst;
            if (hdr.rd) begin
              st_n = ACC_RD;
              tx_n = rd_a;
            end else begin
              st_n = ACC_WR;
            end
          end else begin
            st_n = ACC_SKIP;
          end
        end
        ACC_WR: begin
          we  = 1'b1;
          adv = 1'b1;
          if (!burst_q) st_n = ACC_SKIP;
        end
        ACC_RD: begin
          adv = 1'b1;
          if (burst_q) begin
            tx_n = rd_a;
          end else begin
            st_n = ACC_SKIP;
            tx_n = '0;
          end
        end
        default: ;
      endcase
    end else if (sck_fall && !bit_zero && st_q == ACC_RD) begin
      tx_n = {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= ACC_HDR;
      burst_q <= 1'b0;
      tx_q    <= '0;
    end else begin
      st_q    <= st_n;
      burst_q <= burst_n;
      tx_q    <= tx_n;
    end
  end

  assign spi_miso = tx_q[DATA_W-1];

  // R6
  single_once_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ACC_WR && !burst_q && byte_done && !cs_idle) |=> st_q == ACC_SKIP);
  // R2
  wr_only_in_wr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    we |-> st_q == ACC_WR);
  // R6
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ACC_SKIP) |-> !spi_miso);
endmodule

// File: tb/sim_pwr_table_spi.sv
module sim_pwr_table_spi;
  localparam int HALF = 8;
  localparam logic [7:0] H_WB = 8'h7E, H_RB = 8'hFE, H_WS = 8'h3E,
                         H_RS = 8'hBE, H_OTHER = 8'h7D;
  // each vector: {pa_sel to probe, byte written to entry i in burst}
  localparam logic [10:0] VEC [8] = '{
    {3'd5, 8'hA5}, {3'd0, 8'h3C}, {3'd7, 8'hF0}, {3'd2, 8'h0F},
    {3'd6, 8'h81}, {3'd1, 8'h7E}, {3'd4, 8'h55}, {3'd3, 8'hC3}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, sleep_req = 1'b0;
  logic [2:0] pa_sel = 3'd0;
  logic spi_miso;
  logic [7:0] pa_level;
  logic [7:0] mdl [8];
  logic [7:0] rx;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_table_spi u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sleep_req(sleep_req),
    .pa_sel(pa_sel), .pa_level(pa_level));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    @(negedge clk) spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] r);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      wait_clk(HALF);
      r[b] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic probe(input logic [2:0] sel, output logic [7:0] v);
    pa_sel = sel;
    wait_clk(1);
    v = pa_level;
  endtask

  initial begin
    wait_clk(150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      probe(3'(i), v);
      check("R1 reset entry", v, 8'h00);
      mdl[i] = 8'h00;
    end
    check("R1 miso idle", {7'd0, spi_miso}, 8'h00);

    // R3 burst write from vector table, R8 probe in vector order
    cs_begin();
    xfer(H_WB, rx);
    for (int i = 0; i < 8; i++) begin
      xfer(VEC[i][7:0], rx);
      mdl[i] = VEC[i][7:0];
    end
    cs_end();
    for (int i = 0; i < 8; i++) begin
      probe(VEC[i][10:8], v);
      check("R3/R8 entry via pa_sel", v, mdl[VEC[i][10:8]]);
    end

    // R5 burst read, R4 read wrap on bytes 9 and 10
    cs_begin();
    xfer(H_RB, rx);
    for (int i = 0; i < 10; i++) begin
      xfer(8'h00, rx);
      check(i < 8 ? "R5 burst read" : "R4 read wrap", rx, mdl[i % 8]);
    end
    cs_end();

    // R4 write wrap: ninth byte overwrites entry 0
    cs_begin();
    xfer(H_WB, rx);
    for (int i = 0; i < 9; i++) begin
      xfer(8'h10 + 8'(i), rx);
      mdl[i % 8] = 8'h10 + 8'(i);
    end
    cs_end();
    probe(3'd0, v); check("R4 write wrap entry0", v, 8'h18);
    probe(3'd1, v); check("R4 entry1 intact", v, 8'h11);

    // R6 single write: trailing byte ignored
    cs_begin();
    xfer(H_WS, rx); xfer(8'hE1, rx); xfer(8'hE2, rx);
    cs_end();
    mdl[0] = 8'hE1;
    probe(3'd0, v); check("R6 single write entry0", v, 8'hE1);
    probe(3'd1, v); check("R6 trailing byte ignored", v, mdl[1]);

    // R6 single read: second byte returns zero
    cs_begin();
    xfer(H_RS, rx);
    xfer(8'h00, rx); check("R6 single read first", rx, mdl[0]);
    xfer(8'h00, rx); check("R6 single read trailing", rx, 8'h00);
    cs_end();

    // R2 foreign address leaves table alone
    cs_begin();
    xfer(H_OTHER, rx);
    for (int i = 0; i < 8; i++) xfer(8'hBB, rx);
    cs_end();
    for (int i = 0; i < 8; i++) begin
      probe(3'(i), v);
      check("R2 other address no effect", v, mdl[i]);
    end

    // R7 pointer cleared by chip select
    cs_begin(); xfer(H_WS, rx); xfer(8'h6A, rx); cs_end();
    cs_begin(); xfer(H_WS, rx); xfer(8'h6B, rx); cs_end();
    mdl[0] = 8'h6B;
    probe(3'd0, v); check("R7 second single in entry0", v, 8'h6B);
    probe(3'd1, v); check("R7 entry1 untouched", v, mdl[1]);

    // R9 sleep keeps entry 0 only
    @(negedge clk) sleep_req = 1'b1;
    wait_clk(2);
    sleep_req = 1'b0;
    wait_clk(1);
    for (int i = 1; i < 8; i++) mdl[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin
      probe(3'(i), v);
      check(i == 0 ? "R9 entry0 kept" : "R9 entry cleared", v, mdl[i]);
    end
    cs_begin();
    xfer(H_RB, rx);
    for (int i = 0; i < 8; i++) begin
      xfer(8'h00, rx);
      check("R9/R5 read after sleep", rx, mdl[i]);
    end
    cs_end();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule